// File: doc/BRIEF.md
# Address Translation Buffer with Table Walker

This block turns 32-bit virtual addresses into physical addresses for a processor pipeline. It keeps a small, fully associative set of recent page-to-frame pairs. A request that matches a stored pair is answered from the set without touching memory. A request that matches nothing starts a hardware walk. The walk reads one page-table word from memory, at the table base input plus the page number. A valid word is stored in the set and the request completes with its physical address. An invalid word produces a precise fault response that carries the virtual address that failed.

Only one request is in flight at a time: the request port refuses new work from acceptance until the response cycle. The memory read port uses a valid/ready request channel and a single-cycle response strobe. A flush input drops every stored pair, so that the translations used after a page-table update are fresh ones.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no pair is stored, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: Virtual bits [31:16] are the page number and bits [15:0] are the offset. The physical address is {frame[7:0], offset}, 24 bits wide, with the offset unchanged.
- R3: A walk reads at `ptbase_i` + zero-extended page number. The sum is 32 bits and wraps at 2^32.
- R4: In a page-table word, bit 31 is the valid flag and bits [7:0] are the frame. All other bits are ignored.
- R5: A request that hits is answered with `rsp_valid_o` high on the second rising edge after acceptance, with fault 0, and no memory request is made.
- R6: A miss with a valid word stores the pair and answers with fault 0 and the translated address. A later request to the same page hits.
- R7: A miss with an invalid word answers with `rsp_fault_o`=1 and `rsp_bad_va_o` equal to the request address, and stores nothing, so a repeat request walks again.
- R8: `req_ready_o` is 0 from acceptance until the response cycle. `mem_req_valid_o` stays high with a stable address until `mem_req_ready_i` is seen.
- R9: Fills go to the 8 slots in round-robin order, starting at slot 0 after reset and wrapping after slot 7, whether or not a slot is empty.
- R10: A `flush_i` pulse clears every stored pair, so the next request to any page walks. A flush takes priority over a fill in the same cycle.
- R11: `rsp_kind_o` echoes the request's access kind (00 fetch, 01 load, 10 store), and `rsp_valid_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear all stored pairs |
| ptbase_i | input | 32 | Page-table base address |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Block is idle and accepts a request |
| req_va_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 00 fetch, 01 load, 10 store |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_pa_o | output | 24 | Physical address (0 on fault) |
| rsp_kind_o | output | 2 | Echoed access kind |
| rsp_fault_o | output | 1 | Page not resident |
| rsp_bad_va_o | output | 32 | Faulting virtual address (0 otherwise) |
| mem_req_valid_o | output | 1 | Page-table read request |
| mem_req_ready_i | input | 1 | Memory takes the read request |
| mem_req_addr_o | output | 32 | Page-table word address |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Page-table word |

## Verification
The bench builds the block with its default parameters: a 16/16 page split, 8-bit frames and 8 slots. With only 8 slots, a few dozen requests fill every slot, wrap the replacement pointer and evict a known page, so round-robin order is checked from what hits and what walks. A memory model with a settable stall drives the request-hold rule. Moving the table base near the top of the address space makes the walk address wrap.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WALK_REQ,
    ST_WALK_WAIT,
    ST_FILL,
    ST_FAULT
  } walk_state_e;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 8,
  parameter int PN_W    = 16,
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [PN_W-1:0]    look_pn_i,
  output logic               hit_o,
  output logic [FRAME_W-1:0] hit_frame_o,
  input  logic               fill_en_i,
  input  logic [PN_W-1:0]    fill_pn_i,
  input  logic [FRAME_W-1:0] fill_frame_i
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic               vld_q [ENTRIES];
  logic [PN_W-1:0]    tag_q [ENTRIES];
  logic [FRAME_W-1:0] frm_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   ptr_q;

  // Named event: a fill that actually lands (flush wins, R10)
  logic ev_fill_commit;
  assign ev_fill_commit = fill_en_i && !flush_i;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        frm_q[i] <= '0;
      end else if (flush_i) begin
        vld_q[i] <= 1'b0;
      end else if (ev_fill_commit && ptr_q == IDX_W'(i)) begin
        vld_q[i] <= 1'b1;
        tag_q[i] <= fill_pn_i;
        frm_q[i] <= fill_frame_i;
      end
    end
    assign match[i] = vld_q[i] && (tag_q[i] == look_pn_i);
  end

  // Round-robin victim pointer (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ev_fill_commit) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_comb begin
    hit_frame_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_frame_o = hit_frame_o | frm_q[i];
    end
  end
  assign hit_o = |match;

  // Fills happen only on misses, so a page never sits in two slots
  assert_unique_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !hit_o);

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PN_W    = 16,
  parameter int FRAME_W = 8,
  parameter int MA_W    = 32,
  parameter int MD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [MA_W-1:0]             ptbase_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [VA_W-1:0]             req_va_i,
  input  logic [1:0]                  req_kind_i,
  output logic                        rsp_valid_o,
  output logic [FRAME_W+VA_W-PN_W-1:0] rsp_pa_o,
  output logic [1:0]                  rsp_kind_o,
  output logic                        rsp_fault_o,
  output logic [VA_W-1:0]             rsp_bad_va_o,
  output logic                        mem_req_valid_o,
  input  logic                        mem_req_ready_i,
  output logic [MA_W-1:0]             mem_req_addr_o,
  input  logic                        mem_rsp_valid_i,
  input  logic [MD_W-1:0]             mem_rsp_data_i,
  output logic [PN_W-1:0]             look_pn_o,
  input  logic                        hit_i,
  input  logic [FRAME_W-1:0]          hit_frame_i,
  output logic                        fill_en_o,
  output logic [PN_W-1:0]             fill_pn_o,
  output logic [FRAME_W-1:0]          fill_frame_o
);

  localparam int OFF_W     = VA_W - PN_W;
  localparam int PA_W      = FRAME_W + OFF_W;
  localparam int VALID_BIT = MD_W - 1;

  function automatic logic [PN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: PN_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] fr,
                                               input logic [VA_W-1:0] va);
    return {fr, offset_of(va)};
  endfunction

  function automatic logic [MA_W-1:0] pte_addr(input logic [MA_W-1:0] base,
                                               input logic [PN_W-1:0] pn);
    return base + {{(MA_W-PN_W){1'b0}}, pn};
  endfunction

  walk_state_e        state_q, state_d;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         kind_q;
  logic [FRAME_W-1:0] frame_q;
  logic [MA_W-1:0]    maddr_q;

  // Named internal events
  logic ev_accept, ev_hit, ev_miss, ev_walk_issue, ev_pte_arrive, ev_fill, ev_fault;
  assign ev_accept     = req_valid_i && req_ready_o;
  assign ev_hit        = (state_q == ST_LOOKUP) && hit_i;
  assign ev_miss       = (state_q == ST_LOOKUP) && !hit_i;
  assign ev_walk_issue = mem_req_valid_o && mem_req_ready_i;
  assign ev_pte_arrive = (state_q == ST_WALK_WAIT) && mem_rsp_valid_i;
  assign ev_fill       = (state_q == ST_FILL);
  assign ev_fault      = (state_q == ST_FAULT);

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_WALK_REQ);
  assign mem_req_addr_o  = maddr_q;
  assign look_pn_o       = page_of(va_q);
  assign fill_en_o       = ev_fill;
  assign fill_pn_o       = page_of(va_q);
  assign fill_frame_o    = frame_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (ev_accept) state_d = ST_LOOKUP;
      ST_LOOKUP:    state_d = hit_i ? ST_IDLE : ST_WALK_REQ;
      ST_WALK_REQ:  if (mem_req_ready_i) state_d = ST_WALK_WAIT;
      ST_WALK_WAIT: if (mem_rsp_valid_i)
                      state_d = mem_rsp_data_i[VALID_BIT] ? ST_FILL : ST_FAULT;
      ST_FILL:      state_d = ST_IDLE;
      ST_FAULT:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      va_q         <= '0;
      kind_q       <= KIND_FETCH;
      frame_q      <= '0;
      maddr_q      <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_pa_o     <= '0;
      rsp_kind_o   <= KIND_FETCH;
      rsp_fault_o  <= 1'b0;
      rsp_bad_va_o <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= 1'b0;
      if (ev_accept) begin
        va_q   <= req_va_i;
        kind_q <= req_kind_i;
      end
      if (ev_miss) maddr_q <= pte_addr(ptbase_i, page_of(va_q));
      if (ev_pte_arrive) frame_q <= mem_rsp_data_i[FRAME_W-1:0];
      if (ev_hit || ev_fill) begin
        rsp_valid_o  <= 1'b1;
        rsp_pa_o     <= join_pa(ev_hit ? hit_frame_i : frame_q, va_q);
        rsp_kind_o   <= kind_q;
        rsp_fault_o  <= 1'b0;
        rsp_bad_va_o <= '0;
      end else if (ev_fault) begin
        rsp_valid_o  <= 1'b1;
        rsp_pa_o     <= '0;
        rsp_kind_o   <= kind_q;
        rsp_fault_o  <= 1'b1;
        rsp_bad_va_o <= va_q;
      end
    end
  end

  assert_hit_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> rsp_valid_o && !rsp_fault_o && !mem_req_valid_o);

  assert_fill_answers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> rsp_valid_o && !rsp_fault_o);

  assert_fault_va_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> rsp_valid_o && rsp_fault_o && (rsp_bad_va_o == $past(va_q)));

  assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready_o);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_walk_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_walk_issue |=> !mem_req_valid_o);

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int VA_W    = 32,
  parameter int PN_W    = 16,
  parameter int FRAME_W = 8,
  parameter int ENTRIES = 8,
  parameter int MA_W    = 32,
  parameter int MD_W    = 32,
  localparam int PA_W   = FRAME_W + VA_W - PN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [MA_W-1:0]    ptbase_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic [1:0]         req_kind_i,
  output logic               rsp_valid_o,
  output logic [PA_W-1:0]    rsp_pa_o,
  output logic [1:0]         rsp_kind_o,
  output logic               rsp_fault_o,
  output logic [VA_W-1:0]    rsp_bad_va_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [MA_W-1:0]    mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [MD_W-1:0]    mem_rsp_data_i
);

  logic [PN_W-1:0]    look_pn;
  logic               hit;
  logic [FRAME_W-1:0] hit_frame;
  logic               fill_en;
  logic [PN_W-1:0]    fill_pn;
  logic [FRAME_W-1:0] fill_frame;

  xlat_cam #(.ENTRIES(ENTRIES), .PN_W(PN_W), .FRAME_W(FRAME_W)) u_cam (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .look_pn_i(look_pn), .hit_o(hit), .hit_frame_o(hit_frame),
    .fill_en_i(fill_en), .fill_pn_i(fill_pn), .fill_frame_i(fill_frame)
  );

  xlat_walker #(.VA_W(VA_W), .PN_W(PN_W), .FRAME_W(FRAME_W),
                .MA_W(MA_W), .MD_W(MD_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .ptbase_i(ptbase_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_va_i(req_va_i), .req_kind_i(req_kind_i),
    .rsp_valid_o(rsp_valid_o), .rsp_pa_o(rsp_pa_o), .rsp_kind_o(rsp_kind_o),
    .rsp_fault_o(rsp_fault_o), .rsp_bad_va_o(rsp_bad_va_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i),
    .look_pn_o(look_pn), .hit_i(hit), .hit_frame_i(hit_frame),
    .fill_en_o(fill_en), .fill_pn_o(fill_pn), .fill_frame_o(fill_frame)
  );

endmodule

// File: tb/xlat_buffer_bench.sv
`timescale 1ns/1ps
module xlat_buffer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] ptbase = 32'h1000_0000;
  logic        req_valid = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid_o;
  logic [23:0] rsp_pa_o;
  logic [1:0]  rsp_kind_o;
  logic        rsp_fault_o;
  logic [31:0] rsp_bad_va_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2 clk = ~clk;

  xlat_buffer u_xlat_buffer (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ptbase_i(ptbase),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_va_i(req_va), .req_kind_i(req_kind),
    .rsp_valid_o(rsp_valid_o), .rsp_pa_o(rsp_pa_o), .rsp_kind_o(rsp_kind_o),
    .rsp_fault_o(rsp_fault_o), .rsp_bad_va_o(rsp_bad_va_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  logic [31:0] pt_mem [256];
  int checks = 0;
  int errors = 0;
  int walk_cnt = 0;
  int stall_cfg = 0;
  logic [31:0] last_maddr = '0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model: optional request stall, response two cycles after acceptance
  initial begin
    int lat = 0;
    int stall = 0;
    bit busy = 1'b0;
    logic [31:0] paddr = '0;
    logic [31:0] hold = '0;
    logic [31:0] idx;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (busy) begin
        lat--;
        if (lat == 0) begin
          idx = paddr - ptbase;
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pt_mem[idx[7:0]];
          busy = 1'b0;
        end
      end else if (mem_req_valid_o) begin
        if (stall == 0) hold = mem_req_addr_o;
        else chk(mem_req_addr_o == hold, "R8", "held walk address", mem_req_addr_o, hold);
        if (stall < stall_cfg) begin
          stall++;
        end else begin
          mem_req_ready = 1'b1;
          paddr = mem_req_addr_o;
          last_maddr = paddr;
          walk_cnt++;
          busy = 1'b1;
          lat = 2;
          stall = 0;
        end
      end
    end
  end

  task automatic access(input logic [31:0] va, input logic [1:0] kind,
                        input bit exp_walk, input bit exp_fault, input string tag);
    int w0;
    int cyc;
    logic [31:0] pte;
    logic [31:0] exp_addr;
    logic [15:0] vpn;
    vpn = va[31:16];
    pte = pt_mem[vpn[7:0]];
    exp_addr = ptbase + {16'h0, vpn};
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R8", "ready while idle", req_ready_o, 1);
    req_valid = 1'b1; req_va = va; req_kind = kind;
    w0 = walk_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready_o == 1'b0, "R8", "refused while busy", req_ready_o, 0);
    cyc = 0;
    while (!rsp_valid_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk((walk_cnt - w0) == int'(exp_walk), tag, "walk count", walk_cnt - w0, exp_walk);
    if (exp_walk) chk(last_maddr == exp_addr, "R3", "walk address", last_maddr, exp_addr);
    else chk(cyc == 1, "R5", "hit latency", cyc, 1);
    chk(rsp_fault_o == exp_fault, tag, "fault flag", rsp_fault_o, exp_fault);
    chk(rsp_kind_o == kind, "R11", "kind echo", rsp_kind_o, kind);
    if (exp_fault) chk(rsp_bad_va_o == va, "R7", "bad va", rsp_bad_va_o, va);
    else chk(rsp_pa_o == {pte[7:0], va[15:0]}, "R2", "physical address",
             rsp_pa_o, {pte[7:0], va[15:0]});
    @(negedge clk);
    chk(rsp_valid_o == 1'b0, "R11", "single response pulse", rsp_valid_o, 0);
  endtask

  // {va, kind, walk, fault, rr}
  localparam int NV = 17;
  localparam logic [36:0] TV [NV] = '{
    {32'h0040_0010, 2'd0, 1'b1, 1'b0, 1'b0},
    {32'h0040_1234, 2'd1, 1'b0, 1'b0, 1'b0},
    {32'h0053_1020, 2'd1, 1'b1, 1'b1, 1'b0},
    {32'h0053_1020, 2'd2, 1'b1, 1'b1, 1'b0},
    {32'h0040_FFFF, 2'd2, 1'b0, 1'b0, 1'b0},
    {32'h0010_00A5, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0011_00A5, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0012_00A5, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0013_00A5, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0014_00A5, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0015_00A5, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0016_00A5, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0017_0000, 2'd0, 1'b1, 1'b0, 1'b1},
    {32'h0010_0001, 2'd1, 1'b0, 1'b0, 1'b1},
    {32'h0040_0010, 2'd0, 1'b1, 1'b0, 1'b1},
    {32'h0010_0002, 2'd1, 1'b1, 1'b0, 1'b1},
    {32'h0012_0003, 2'd1, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    for (int i = 0; i < 256; i++) pt_mem[i] = 32'h0;
    pt_mem[8'h40] = 32'h8ABC_DE07;   // R4: stray bits ignored
    pt_mem[8'h53] = 32'h0000_0014;   // invalid, frame bits set
    for (int i = 0; i < 9; i++) pt_mem[8'h10 + i] = 32'h8000_0020 + i;
    pt_mem[8'h20] = 32'h8000_005A;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R1", "no response in reset", rsp_valid_o, 0);
    chk(mem_req_valid_o == 1'b0, "R1", "no walk in reset", mem_req_valid_o, 0);
    rst_n = 1'b1;

    // Vector table: R5, R6, R7, R9 (rows tagged rr check round-robin order)
    for (int v = 0; v < NV; v++) begin
      string tag;
      if (TV[v][0]) tag = "R9";
      else if (TV[v][1]) tag = "R7";
      else if (TV[v][2]) tag = "R6";
      else tag = "R5";
      access(TV[v][36:5], TV[v][4:3], TV[v][2], TV[v][1], tag);
    end

    // R10: flush drops every pair
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    access(32'h0012_0004, 2'd1, 1'b1, 1'b0, "R10");
    access(32'h0017_0008, 2'd2, 1'b1, 1'b0, "R10");

    // R8: stalled memory request must hold its address
    stall_cfg = 3;
    access(32'h0018_0000, 2'd2, 1'b1, 1'b0, "R8");
    stall_cfg = 0;

    // R3: base plus page number wraps at 2^32
    ptbase = 32'hFFFF_FFF0;
    access(32'h0020_0ABC, 2'd0, 1'b1, 1'b0, "R3");
    chk(last_maddr == 32'h0000_0010, "R3", "wrapped walk address", last_maddr, 32'h10);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule